// File: doc/BRIEF.md
# RTC Register Front End

This block is the byte-register layer of a real-time-clock device that also carries a small battery-backed RAM. It sits behind a byte-level serial target that has already decoded the bus. That target delivers one-cycle pulses for the start of a write transaction and the start of a read transaction. It also delivers a write strobe with its data byte, and a read strobe whose data the block must return in the same cycle. Behind the block, a time-keeping core counts time and presents seconds, minutes, hours, weekday, day, month and year as parallel BCD fields. The same core reports when its oscillator has stopped.

The block holds a 64-byte register space. The lowest seven bytes are a snapshot of the time fields. The next byte is a control register. Everything above is plain RAM. A register pointer selects the byte for each access. The first byte of a write transaction loads that pointer. The time snapshot is taken at the start of each read transaction and again each time the pointer wraps, so a burst read always sees one consistent instant. A write to a time byte is not stored. It is passed to the time-keeping core as a one-cycle load request.

Top module: `rtc_regfront`

## Requirements
- R1: After reset every one of the 64 bytes reads 0x00 and the pointer is 0.
- R2: The first write byte after a write start is not stored, does not raise the load strobe and does not advance the pointer; its low 6 bits become the new pointer.
- R3: Every later write byte and every read byte advance the pointer by one after the access, wrapping from 63 to 0.
- R4: On a read start, time field k (bits 8k+7..8k of the time input, k=0 seconds up to k=6 year) is copied into byte k. Bytes 0..6 change at no other time except as in R5.
- R5: When an access advances the pointer from 63 to 0, bytes 0..6 are recaptured from the time input at that same edge.
- R6: A write to byte 7 stores the data ANDed with 0xB3, so bits 2, 3 and 6 of byte 7 always read 0.
- R7: Bit 5 of byte 7 (oscillator-stop flag) is set by a pulse on tk_osc_stop_i. Writing 1 to it leaves it unchanged, and writing 0 clears it.
- R8: A data write at address k in 0..6 raises ld_stb_o for that cycle with ld_idx_o = k. ld_data_o is the write data ANDed with the field mask for k: 0x7F, 0x7F, 0x7F, 0x07, 0x3F, 0x1F, 0xFF for k = 0 to 6. Byte k itself is left unchanged.
- R9: A data write to address 8..63 is stored there and reads back unchanged; it raises no load strobe.
- R10: rd_data_o always shows the byte the pointer currently selects, so read data is valid in the same cycle as rd_byte_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start_i | input | 1 | Pulse: a write transaction begins |
| rd_start_i | input | 1 | Pulse: a read transaction begins (captures time) |
| wr_byte_i | input | 1 | Pulse: a write byte is present on wr_data_i |
| wr_data_i | input | 8 | Write byte |
| rd_byte_i | input | 1 | Pulse: the current byte is being read |
| rd_data_o | output | 8 | Byte selected by the pointer |
| tk_time_i | input | 56 | Running time, field k at bits 8k+7..8k |
| tk_osc_stop_i | input | 1 | Pulse: oscillator stop detected |
| ld_stb_o | output | 1 | Load request toward the time-keeping core |
| ld_idx_o | output | 3 | Time field index for the load |
| ld_data_o | output | 8 | Masked field value for the load |

## Verification
The bench builds the block with its default parameters: a 6-bit pointer over 64 bytes, seven time fields and the 0xB3 control mask. With these values the 63-to-0 wrap is reached within one address byte plus one access, in both the write and the read direction. Every time-field mask and every control-bit rule can also be driven directly. Each time value the bench uses has distinct fields, so a missed or stray capture shows up as a mismatched byte.

// File: rtl/rtcr_pkg.sv
package rtcr_pkg;

   // Load-data mask for each time field index (0 = seconds .. 6 = year).
   function automatic logic [7:0] field_mask(input logic [2:0] idx);
      logic [7:0] m;
      case (idx)
         3'd0:    m = 8'h7F;
         3'd1:    m = 8'h7F;
         3'd2:    m = 8'h7F;
         3'd3:    m = 8'h07;
         3'd4:    m = 8'h3F;
         3'd5:    m = 8'h1F;
         default: m = 8'hFF;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/rtcr_ptr.sv
module rtcr_ptr #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_start_i,
   input  logic              wr_byte_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_byte_i,
   output logic [ADDR_W-1:0] ptr_o,
   output logic              data_wr_o,
   output logic              wrap_o
);
   localparam logic [ADDR_W-1:0] PTR_TOP = '1;

   logic [ADDR_W-1:0] ptr_q;
   logic              aph_q;
   logic              step;

   assign data_wr_o = wr_byte_i && !aph_q;
   assign step      = data_wr_o || rd_byte_i;
   assign wrap_o    = step && (ptr_q == PTR_TOP);
   assign ptr_o     = ptr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
         aph_q <= 1'b0;
      end else begin
         if (wr_byte_i && aph_q) begin
            ptr_q <= wr_data_i[ADDR_W-1:0];
            aph_q <= 1'b0;
         end else if (step) begin
            ptr_q <= ptr_q + 1'b1;
         end
         if (wr_start_i) aph_q <= 1'b1;
      end
   end

   // R2: address byte loads the pointer
   p_addr_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_byte_i && aph_q && !wr_start_i) |=> (ptr_q == $past(wr_data_i[ADDR_W-1:0])));

   // R3: each data access advances by one, modulo the space
   p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wr_start_i) |=> (ptr_q == ADDR_W'($past(ptr_q) + 1'b1)));

endmodule

// File: rtl/rtcr_ctrl_rule.sv
module rtcr_ctrl_rule #(
   parameter int              DATA_W  = 8,
   parameter logic [DATA_W-1:0] WMASK = 8'hB3,
   parameter int              OSF_BIT = 5
) (
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] cur_i,
   output logic [DATA_W-1:0] next_o
);
   localparam logic [DATA_W-1:0] CLR_ONLY = DATA_W'(1) << OSF_BIT;

   // Writable bits take the data; the clear-only flag can only fall.
   always_comb begin
      next_o = (wdata_i & WMASK & ~CLR_ONLY) | (wdata_i & cur_i & CLR_ONLY);
   end

endmodule

// File: rtl/rtcr_regs.sv
module rtcr_regs #(
   parameter int                ADDR_W    = 6,
   parameter int                DATA_W    = 8,
   parameter int                TIME_REGS = 7,
   parameter logic [DATA_W-1:0] WMASK     = 8'hB3,
   parameter int                OSF_BIT   = 5
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [ADDR_W-1:0]              ptr_i,
   input  logic                           wr_en_i,
   input  logic [DATA_W-1:0]              wr_data_i,
   input  logic                           cap_i,
   input  logic [TIME_REGS*DATA_W-1:0]    time_i,
   input  logic                           osc_stop_i,
   output logic [DATA_W-1:0]              rd_data_o
);
   localparam int DEPTH     = 1 << ADDR_W;
   localparam int CTRL_ADDR = TIME_REGS;

   logic [DATA_W-1:0] q [DEPTH];

   for (genvar k = 0; k < DEPTH; k++) begin : g_ent
      logic [DATA_W-1:0] r_q;
      logic              sel;
      assign sel = wr_en_i && (ptr_i == ADDR_W'(k));

      if (k < TIME_REGS) begin : g_time
         always_ff @(posedge clk) begin
            if (!rst_n)     r_q <= '0;
            else if (cap_i) r_q <= time_i[k*DATA_W +: DATA_W];
         end
      end else if (k == CTRL_ADDR) begin : g_ctrl
         logic [DATA_W-1:0] nxt;
         rtcr_ctrl_rule #(
            .DATA_W (DATA_W),
            .WMASK  (WMASK),
            .OSF_BIT(OSF_BIT)
         ) u_rule (
            .wdata_i(wr_data_i),
            .cur_i  (r_q),
            .next_o (nxt)
         );
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               r_q <= '0;
            end else begin
               if (sel)        r_q          <= nxt;
               if (osc_stop_i) r_q[OSF_BIT] <= 1'b1;
            end
         end

         // R6: masked bits never appear in the control byte
         p_ctrl_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
            sel |=> ((r_q & ~WMASK) == '0));

         // R7: the flag rises only when the core reports a stop
         p_osf_clronly_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!osc_stop_i && sel && !r_q[OSF_BIT]) |=> !r_q[OSF_BIT]);
      end else begin : g_ram
         always_ff @(posedge clk) begin
            if (!rst_n)   r_q <= '0;
            else if (sel) r_q <= wr_data_i;
         end
      end

      assign q[k] = r_q;
   end

   assign rd_data_o = q[ptr_i];

   // R4/R5: capture loads the running seconds field
   p_snap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i |=> (q[0] == $past(time_i[DATA_W-1:0])));

   // R4: without a capture the snapshot holds
   p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_i && !$fell(rst_n)) |=> $stable(q[0]));

endmodule

// File: rtl/rtc_regfront.sv
module rtc_regfront #(
   parameter int                ADDR_W    = 6,
   parameter int                DATA_W    = 8,
   parameter int                TIME_REGS = 7,
   parameter logic [DATA_W-1:0] WMASK     = 8'hB3,
   parameter int                OSF_BIT   = 5
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_start_i,
   input  logic                        rd_start_i,
   input  logic                        wr_byte_i,
   input  logic [DATA_W-1:0]           wr_data_i,
   input  logic                        rd_byte_i,
   output logic [DATA_W-1:0]           rd_data_o,
   input  logic [TIME_REGS*DATA_W-1:0] tk_time_i,
   input  logic                        tk_osc_stop_i,
   output logic                        ld_stb_o,
   output logic [2:0]                  ld_idx_o,
   output logic [DATA_W-1:0]           ld_data_o
);
   import rtcr_pkg::*;

   localparam logic [ADDR_W-1:0] TIME_TOP = ADDR_W'(TIME_REGS);

   // Elaboration-time parameter checks
   if (ADDR_W < 4 || ADDR_W > 10) begin : g_bad_addr
      $error("ADDR_W out of range");
   end
   if (DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be at least 8");
   end
   if (TIME_REGS < 1 || TIME_REGS > 7) begin : g_bad_time
      $error("TIME_REGS must be 1..7");
   end
   if (OSF_BIT >= DATA_W) begin : g_bad_osf
      $error("OSF_BIT outside the data byte");
   end

   logic [ADDR_W-1:0] ptr;
   logic              data_wr;
   logic              wrap;
   logic              cap;

   rtcr_ptr #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_start_i(wr_start_i),
      .wr_byte_i (wr_byte_i),
      .wr_data_i (wr_data_i),
      .rd_byte_i (rd_byte_i),
      .ptr_o     (ptr),
      .data_wr_o (data_wr),
      .wrap_o    (wrap)
   );

   assign cap = rd_start_i || wrap;

   rtcr_regs #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .TIME_REGS(TIME_REGS),
      .WMASK    (WMASK),
      .OSF_BIT  (OSF_BIT)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ptr_i     (ptr),
      .wr_en_i   (data_wr),
      .wr_data_i (wr_data_i),
      .cap_i     (cap),
      .time_i    (tk_time_i),
      .osc_stop_i(tk_osc_stop_i),
      .rd_data_o (rd_data_o)
   );

   // Load request toward the time-keeping core
   assign ld_stb_o  = data_wr && (ptr < TIME_TOP);
   assign ld_idx_o  = 3'(ptr);
   assign ld_data_o = wr_data_i & DATA_W'(field_mask(3'(ptr)));

   // R8: a load names a time field
   p_ld_idx_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ld_stb_o |-> (ld_idx_o < 3'(TIME_REGS)) && wr_byte_i);

   // R9: RAM writes never request a time load
   p_ram_noload_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_byte_i && ptr > TIME_TOP) |-> !ld_stb_o);

endmodule

// File: tb/sim_rtc_regfront.sv
module sim_rtc_regfront;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_start = 1'b0, rd_start = 1'b0, wr_byte = 1'b0, rd_byte = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic [55:0] tk_time = '0;
   logic        osc_stop = 1'b0;
   logic        ld_stb;
   logic [2:0]  ld_idx;
   logic [7:0]  ld_data;

   int tests = 0, fails = 0;
   logic       s_stb;
   logic [2:0] s_idx;
   logic [7:0] s_dat;

   always #10 clk = ~clk;

   rtc_regfront u0 (
      .clk(clk), .rst_n(rst_n),
      .wr_start_i(wr_start), .rd_start_i(rd_start),
      .wr_byte_i(wr_byte), .wr_data_i(wr_data),
      .rd_byte_i(rd_byte), .rd_data_o(rd_data),
      .tk_time_i(tk_time), .tk_osc_stop_i(osc_stop),
      .ld_stb_o(ld_stb), .ld_idx_o(ld_idx), .ld_data_o(ld_data)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic p_wstart();
      @(negedge clk); wr_start = 1'b1;
      @(negedge clk); wr_start = 1'b0;
   endtask

   task automatic p_rstart();
      @(negedge clk); rd_start = 1'b1;
      @(negedge clk); rd_start = 1'b0;
   endtask

   task automatic p_osc();
      @(negedge clk); osc_stop = 1'b1;
      @(negedge clk); osc_stop = 1'b0;
   endtask

   task automatic p_wbyte(input logic [7:0] d);
      @(negedge clk); wr_byte = 1'b1; wr_data = d;
      #1; s_stb = ld_stb; s_idx = ld_idx; s_dat = ld_data;
      @(negedge clk); wr_byte = 1'b0;
   endtask

   task automatic p_rbyte(output logic [7:0] d);
      @(negedge clk); rd_byte = 1'b1;
      #1; d = rd_data;
      @(negedge clk); rd_byte = 1'b0;
   endtask

   task automatic set_ptr(input logic [7:0] a);
      p_wstart();
      p_wbyte(a);
   endtask

   // Scenario: reset state
   task automatic t_reset();
      logic [7:0] d;
      set_ptr(8'd0);
      chk("R2 address byte raises no load", {7'd0, s_stb}, 8'h00);
      p_rbyte(d); chk("R1 byte 0 after reset", d, 8'h00);
      set_ptr(8'd7);  p_rbyte(d); chk("R1 byte 7 after reset", d, 8'h00);
      set_ptr(8'd40); p_rbyte(d); chk("R1 byte 40 after reset", d, 8'h00);
      set_ptr(8'd63); p_rbyte(d); chk("R1 byte 63 after reset", d, 8'h00);
   endtask

   // Scenario: RAM access and address byte handling
   task automatic t_ram();
      logic [7:0] d;
      set_ptr(8'd8);
      p_wbyte(8'hA5); chk("R9 RAM write raises no load", {7'd0, s_stb}, 8'h00);
      p_wbyte(8'h5A);
      set_ptr(8'd8);
      #1; chk("R10 read data follows pointer", rd_data, 8'hA5);
      p_rbyte(d); chk("R9 RAM readback 8", d, 8'hA5);
      p_rbyte(d); chk("R3 read after advance", d, 8'h5A);
      p_wstart(); p_wbyte(8'h53); p_wbyte(8'h77);
      set_ptr(8'h13); p_rbyte(d); chk("R2 pointer takes low 6 bits", d, 8'h77);
      set_ptr(8'h10); p_rbyte(d); chk("R2 address byte not stored", d, 8'h00);
   endtask

   // Scenario: snapshot on read start
   task automatic t_snap();
      logic [7:0] d;
      logic [55:0] ta;
      ta = {8'h24, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h58};
      tk_time = ta;
      set_ptr(8'd0);
      p_rstart();
      for (int k = 0; k < 7; k++) begin
         p_rbyte(d); chk("R4 snapshot field", d, ta[k*8 +: 8]);
      end
      tk_time = {8'h25, 8'h02, 8'h14, 8'h03, 8'h11, 8'h22, 8'h33};
      set_ptr(8'd0); p_rbyte(d); chk("R4 no capture without read start", d, 8'h58);
   endtask

   // Scenario: pointer wrap recapture
   task automatic t_wrap();
      logic [7:0] d;
      set_ptr(8'd63);
      p_wbyte(8'hC9);
      p_rbyte(d); chk("R5 write wrap captures seconds", d, 8'h33);
      p_rbyte(d); chk("R5 write wrap captures minutes", d, 8'h22);
      tk_time = {8'h26, 8'h03, 8'h15, 8'h04, 8'h12, 8'h44, 8'h01};
      set_ptr(8'd63);
      p_rbyte(d); chk("R3 byte 63 read before wrap", d, 8'hC9);
      p_rbyte(d); chk("R5 read wrap captures seconds", d, 8'h01);
   endtask

   // Scenario: control register rules
   task automatic t_ctrl();
      logic [7:0] d;
      set_ptr(8'd7); p_wbyte(8'hFF);
      set_ptr(8'd7); p_rbyte(d); chk("R6 control masked with B3", d, 8'h93);
      p_osc();
      set_ptr(8'd7); p_rbyte(d); chk("R7 stop flag set by core", d, 8'hB3);
      set_ptr(8'd7); p_wbyte(8'hFF);
      set_ptr(8'd7); p_rbyte(d); chk("R7 writing 1 keeps flag", d, 8'hB3);
      set_ptr(8'd7); p_wbyte(8'hDF);
      set_ptr(8'd7); p_rbyte(d); chk("R7 writing 0 clears flag", d, 8'h93);
      set_ptr(8'd7); p_wbyte(8'h4C);
      set_ptr(8'd7); p_rbyte(d); chk("R6 bits 2,3,6 read zero", d, 8'h00);
   endtask

   // Scenario: time field load requests
   task automatic t_load();
      logic [7:0] d;
      logic [7:0] exp_mask [7] = '{8'h7F, 8'h7F, 8'h7F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
      p_rstart();
      set_ptr(8'd0);
      for (int k = 0; k < 7; k++) begin
         p_wbyte(8'hFF);
         chk("R8 load strobe", {7'd0, s_stb}, 8'h01);
         chk("R8 load index", {5'd0, s_idx}, 8'(k));
         chk("R8 load data masked", s_dat, exp_mask[k]);
      end
      p_wbyte(8'h00); chk("R8 no load at control", {7'd0, s_stb}, 8'h00);
      set_ptr(8'd2); p_wbyte(8'hF2); chk("R8 hour data", s_dat, 8'h72);
      set_ptr(8'd2); p_rbyte(d); chk("R8 time byte unchanged by write", d, tk_time[23:16]);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ram();
      t_snap();
      t_wrap();
      t_ctrl();
      t_load();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule